// File: doc/BRIEF.md
# Codec Power-Up Reset Sequencer

This block sits on the host side of an attached audio converter/DSP device and owns the two active-low reset lines that device needs: an initialization reset and a system reset. After the power-good input is seen, both lines stay low for a configurable oscillator settling time. Then the initialization reset is released. The block then waits for the device's PLL to lock. That wait lasts 15 ms or 22 ms, depending on a 2-bit clock-select code. When the wait ends, the system reset is released and a ready flag tells the host that command and program transfers may start. A second flag reports when the device's clock outputs are known to be running, which is 12 ms after the initialization reset is released.

The host may ask to stop the device's clocks. The sequencer grants that only while the system reset is low. It first pulls the system reset down and then raises a stop-permission flag. When the request is withdrawn, the permission is removed before the system reset is released again. The initialization reset is not pulsed again for these stop/restart cycles. Only a loss of power-good sends the sequencer back to its all-reset state, from which a full new power-up follows.

All millisecond intervals come from a prescaler derived from the clock-frequency parameter `CLK_HZ`. One millisecond is `CLK_HZ/1000` clock cycles, written `D` below.

Top module: `codec_rst_seq`

## Requirements
- R1: During controller reset, and while power-good is low, `init_rst_no`, `sys_rst_no`, `ready_o`, `clkout_ok_o` and `clk_stop_ok_o` are all 0. A clock-stop request has no effect then.
- R2: Power-good passes through a two-stage synchronizer. Power-good rises and is sampled at clock edge 1. `init_rst_no` then rises at edge `3 + SETTLE_MS*D`.
- R3: `clk_sel_i` is sampled in the cycle the initialization reset is released. Later changes to it do not alter the lock wait.
- R4: `sys_rst_no` and `ready_o` rise together `LOCK_SHORT_MS*D` cycles after `init_rst_no` rises when the sampled code is 0. The wait is `LOCK_LONG_MS*D` cycles for codes 1, 2 and 3. Code 3 is reserved and takes the long wait.
- R5: `sys_rst_no` is never 1 while `init_rst_no` is 0.
- R6: `clkout_ok_o` rises `CLKOUT_MS*D` cycles after `init_rst_no` rises. It stays 1 until power is lost.
- R7: While ready, a stop request is handled over several cycles. `sys_rst_no` and `ready_o` drop one cycle after the request. `clk_stop_ok_o` rises one cycle after that. When the request drops, `clk_stop_ok_o` falls one cycle later. `sys_rst_no` and `ready_o` rise one cycle after that. `clk_stop_ok_o` is never 1 while `sys_rst_no` is 1.
- R8: If a stop request is active when the lock wait ends, `sys_rst_no` is not released. `clk_stop_ok_o` rises in that same cycle instead.
- R9: `init_rst_no` stays 1 through any number of stop/resume cycles. It falls only after power-good is lost.
- R10: Three cycles after power-good falls, all outputs are 0. This holds in any state, including during the lock wait. A later rise of power-good repeats the full sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Controller reset, asynchronous assert, active low |
| pwr_good_i | input | 1 | Supplies valid, asynchronous |
| clk_sel_i | input | 2 | Device clock-select code (0: short lock wait, 1..3: long) |
| clk_stop_req_i | input | 1 | Host asks to stop device clocks |
| init_rst_no | output | 1 | Device initialization reset, active low |
| sys_rst_no | output | 1 | Device system reset, active low |
| ready_o | output | 1 | Command and program transfers permitted |
| clkout_ok_o | output | 1 | Device clock outputs have started |
| clk_stop_ok_o | output | 1 | Device clocks may be stopped now |

## Verification
Two cases are provoked on purpose. In the first, a stop request is already active when the lock timer expires, so the release of the system reset and the grant of clock-stop permission compete for the same edge. The bench holds the request from before power-up and expects permission exactly at the lock deadline, with the system reset never rising. In the second, the clock-select code is changed and power-good is dropped at random points inside the lock wait. A lock-deadline release must never win over a power loss, and the changed code must not shift the deadline. Every release time is compared with the cycle count the bench computes from the requirement.

// File: rtl/crs_pkg.sv
package crs_pkg;

  typedef enum logic [2:0] {
    ST_OFF      = 3'd0,
    ST_SETTLE   = 3'd1,
    ST_LOCK     = 3'd2,
    ST_READY    = 3'd3,
    ST_HALT_RST = 3'd4,
    ST_HALTED   = 3'd5,
    ST_RESUME   = 3'd6
  } crs_state_e;

  typedef struct packed {
    logic init_rst_n;
    logic sys_rst_n;
    logic ready;
    logic stop_ok;
  } crs_pins_t;

  function automatic crs_pins_t crs_decode(crs_state_e st);
    crs_pins_t p;
    p = '0;
    case (st)
      ST_LOCK:     p.init_rst_n = 1'b1;
      ST_READY:    begin
                     p.init_rst_n = 1'b1;
                     p.sys_rst_n  = 1'b1;
                     p.ready      = 1'b1;
                   end
      ST_HALT_RST: p.init_rst_n = 1'b1;
      ST_HALTED:   begin
                     p.init_rst_n = 1'b1;
                     p.stop_ok    = 1'b1;
                   end
      ST_RESUME:   p.init_rst_n = 1'b1;
      default:     p = '0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/crs_sync.sv
module crs_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic meta_q;
    logic sync_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= d_i[b];
        sync_q <= meta_q;
      end
    end

    assign q_o[b] = sync_q;
  end

endmodule

// File: rtl/crs_ms_timer.sv
module crs_ms_timer #(
  parameter int CYC_PER_MS = 100000,
  parameter int MS_W       = 5,
  localparam int PRE_W     = $clog2(CYC_PER_MS + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            run_i,
  output logic            tick_o,
  output logic [MS_W-1:0] ms_o
);

  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_MS - 1);

  logic [PRE_W-1:0] pre_q, pre_n;
  logic [MS_W-1:0]  ms_q,  ms_n;
  logic             wrap;

  assign wrap = (pre_q == PRE_LAST);

  always_comb begin
    pre_n = pre_q;
    ms_n  = ms_q;
    if (clr_i) begin
      pre_n = '0;
      ms_n  = '0;
    end else if (run_i) begin
      if (wrap) begin
        pre_n = '0;
        ms_n  = ms_q + 1'b1;
      end else begin
        pre_n = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      ms_q  <= '0;
    end else begin
      pre_q <= pre_n;
      ms_q  <= ms_n;
    end
  end

  assign tick_o = run_i && wrap;
  assign ms_o   = ms_q;

endmodule

// File: rtl/crs_seq_fsm.sv
module crs_seq_fsm
  import crs_pkg::*;
#(
  parameter int SETTLE_MS     = 5,
  parameter int LOCK_SHORT_MS = 15,
  parameter int LOCK_LONG_MS  = 22,
  parameter int CLKOUT_MS     = 12,
  parameter int MS_W          = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pwr_ok_i,
  input  logic [1:0]      clk_sel_i,
  input  logic            stop_req_i,
  input  logic            tick_i,
  input  logic [MS_W-1:0] ms_i,
  output logic            timer_clr_o,
  output logic            timer_run_o,
  output logic            init_rst_no,
  output logic            sys_rst_no,
  output logic            ready_o,
  output logic            clkout_ok_o,
  output logic            stop_ok_o
);

  localparam logic [MS_W-1:0] SETTLE_LAST = MS_W'(SETTLE_MS - 1);
  localparam logic [MS_W-1:0] SHORT_LAST  = MS_W'(LOCK_SHORT_MS - 1);
  localparam logic [MS_W-1:0] LONG_LAST   = MS_W'(LOCK_LONG_MS - 1);
  localparam logic [MS_W-1:0] CLKOUT_LAST = MS_W'(CLKOUT_MS - 1);

  crs_state_e      state_q, state_n;
  logic [1:0]      sel_q, sel_n;
  logic            sel_en;
  logic            clkout_q, clkout_n;
  crs_pins_t       pins_q, pins_n;
  logic [MS_W-1:0] tgt_last;
  logic            wait_done;

  // Deadline of the timed state currently active
  always_comb begin
    tgt_last = SETTLE_LAST;
    if (state_q == ST_LOCK) begin
      tgt_last = (sel_q == 2'd0) ? SHORT_LAST : LONG_LAST;
    end
  end

  assign wait_done = tick_i && (ms_i == tgt_last);

  // Next-state logic; power loss overrides every other transition
  always_comb begin
    state_n = state_q;
    if (!pwr_ok_i) begin
      state_n = ST_OFF;
    end else begin
      case (state_q)
        ST_OFF:      state_n = ST_SETTLE;
        ST_SETTLE:   if (wait_done) state_n = ST_LOCK;
        ST_LOCK:     if (wait_done) state_n = stop_req_i ? ST_HALTED : ST_READY;
        ST_READY:    if (stop_req_i) state_n = ST_HALT_RST;
        ST_HALT_RST: state_n = ST_HALTED;
        ST_HALTED:   if (!stop_req_i) state_n = ST_RESUME;
        ST_RESUME:   state_n = stop_req_i ? ST_HALTED : ST_READY;
        default:     state_n = ST_OFF;
      endcase
    end
  end

  assign timer_clr_o = (state_n != state_q);
  assign timer_run_o = (state_q == ST_SETTLE) || (state_q == ST_LOCK);

  // Clock-select capture at the initialization-reset release (R3)
  assign sel_en = (state_q == ST_SETTLE) && (state_n == ST_LOCK);
  assign sel_n  = sel_en ? clk_sel_i : sel_q;

  // Clock-output-started flag (R6)
  always_comb begin
    clkout_n = clkout_q;
    if (state_n == ST_OFF) begin
      clkout_n = 1'b0;
    end else if ((state_q == ST_LOCK) && tick_i && (ms_i == CLKOUT_LAST)) begin
      clkout_n = 1'b1;
    end
  end

  assign pins_n = crs_decode(state_n);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_OFF;
      sel_q    <= 2'd0;
      clkout_q <= 1'b0;
      pins_q   <= '0;
    end else begin
      state_q  <= state_n;
      sel_q    <= sel_n;
      clkout_q <= clkout_n;
      pins_q   <= pins_n;
    end
  end

  assign init_rst_no = pins_q.init_rst_n;
  assign sys_rst_no  = pins_q.sys_rst_n;
  assign ready_o     = pins_q.ready;
  assign stop_ok_o   = pins_q.stop_ok;
  assign clkout_ok_o = clkout_q;

  // Reset ordering
  assert_sys_needs_init_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pins_q.sys_rst_n |-> pins_q.init_rst_n);

  assert_ready_implies_sys_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pins_q.ready |-> pins_q.sys_rst_n);

  // Clock gating only under system reset
  assert_stop_only_in_reset_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pins_q.stop_ok |-> !pins_q.sys_rst_n);

  assert_release_after_ungate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pins_q.sys_rst_n) |-> !$past(pins_q.stop_ok));

  // Power loss
  assert_power_loss_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok_i |=> (!pins_q.init_rst_n && !pins_q.sys_rst_n && !clkout_q));

  assert_init_fall_power_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pins_q.init_rst_n) |-> !$past(pwr_ok_i));

endmodule

// File: rtl/codec_rst_seq.sv
module codec_rst_seq #(
  parameter int CLK_HZ        = 100_000_000,
  parameter int SETTLE_MS     = 5,
  parameter int LOCK_SHORT_MS = 15,
  parameter int LOCK_LONG_MS  = 22,
  parameter int CLKOUT_MS     = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_good_i,
  input  logic [1:0] clk_sel_i,
  input  logic       clk_stop_req_i,
  output logic       init_rst_no,
  output logic       sys_rst_no,
  output logic       ready_o,
  output logic       clkout_ok_o,
  output logic       clk_stop_ok_o
);

  localparam int CYC_PER_MS = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;
  localparam int MAX_A      = (SETTLE_MS > LOCK_LONG_MS) ? SETTLE_MS : LOCK_LONG_MS;
  localparam int MAX_MS     = (MAX_A > LOCK_SHORT_MS) ? MAX_A : LOCK_SHORT_MS;
  localparam int MS_W       = $clog2(MAX_MS + 2);

  logic            pwr_ok;
  logic            timer_clr;
  logic            timer_run;
  logic            tick;
  logic [MS_W-1:0] ms_cnt;

  crs_sync #(.W(1)) u_pwr_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pwr_good_i),
    .q_o    (pwr_ok)
  );

  crs_ms_timer #(
    .CYC_PER_MS (CYC_PER_MS),
    .MS_W       (MS_W)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (timer_clr),
    .run_i  (timer_run),
    .tick_o (tick),
    .ms_o   (ms_cnt)
  );

  crs_seq_fsm #(
    .SETTLE_MS     (SETTLE_MS),
    .LOCK_SHORT_MS (LOCK_SHORT_MS),
    .LOCK_LONG_MS  (LOCK_LONG_MS),
    .CLKOUT_MS     (CLKOUT_MS),
    .MS_W          (MS_W)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pwr_ok_i    (pwr_ok),
    .clk_sel_i   (clk_sel_i),
    .stop_req_i  (clk_stop_req_i),
    .tick_i      (tick),
    .ms_i        (ms_cnt),
    .timer_clr_o (timer_clr),
    .timer_run_o (timer_run),
    .init_rst_no (init_rst_no),
    .sys_rst_no  (sys_rst_no),
    .ready_o     (ready_o),
    .clkout_ok_o (clkout_ok_o),
    .stop_ok_o   (clk_stop_ok_o)
  );

endmodule

// File: tb/codec_rst_seq_tb_top.sv
module codec_rst_seq_tb_top;

  localparam int TB_HZ   = 10_000;
  localparam int D       = TB_HZ / 1000;
  localparam int SET_MS  = 5;
  localparam int SHORT   = 15;
  localparam int LONG    = 22;
  localparam int CKO_MS  = 12;

  logic       clk;
  logic       rst_n;
  logic       pwr_good;
  logic [1:0] clk_sel;
  logic       stop_req;
  logic       init_rst_n, sys_rst_n, ready, clkout_ok, stop_ok;

  int  n_checks;
  int  n_errors;
  bit  finished;

  codec_rst_seq #(
    .CLK_HZ        (TB_HZ),
    .SETTLE_MS     (SET_MS),
    .LOCK_SHORT_MS (SHORT),
    .LOCK_LONG_MS  (LONG),
    .CLKOUT_MS     (CKO_MS)
  ) dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .pwr_good_i     (pwr_good),
    .clk_sel_i      (clk_sel),
    .clk_stop_req_i (stop_req),
    .init_rst_no    (init_rst_n),
    .sys_rst_no     (sys_rst_n),
    .ready_o        (ready),
    .clkout_ok_o    (clkout_ok),
    .clk_stop_ok_o  (stop_ok)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int exp_settle();
    return 3 + SET_MS * D;
  endfunction

  function automatic int exp_lock(input logic [1:0] sel);
    return ((sel == 2'd0) ? SHORT : LONG) * D;
  endfunction

  function automatic int exp_clkout();
    return CKO_MS * D;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Ordering monitors (R5, R7)
  int mon_bad;
  always @(negedge clk) begin
    if (rst_n) begin
      if (sys_rst_n && !init_rst_n) begin
        mon_bad++;
        n_errors++;
        $display("FAIL R5 system reset high while init low actual=1 expected=0");
      end
      if (stop_ok && sys_rst_n) begin
        mon_bad++;
        n_errors++;
        $display("FAIL R7 stop permission with system reset high actual=1 expected=0");
      end
    end
  end

  task automatic all_low(input string tag);
    chk(tag, {init_rst_n, sys_rst_n, ready, clkout_ok, stop_ok}, 0);
  endtask

  // Full power-up; returns with the sequencer ready or halted
  task automatic power_up(input logic [1:0] sel, input bit hold_stop);
    int cnt;
    int c_clk;
    int c_sys;
    int c_stop;
    clk_sel  = sel;
    stop_req = hold_stop;
    @(negedge clk);
    pwr_good = 1'b1;
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!init_rst_n && cnt < 5000);
    chk("R2 init release latency", cnt, exp_settle());
    cnt = 0; c_clk = -1; c_sys = -1; c_stop = -1;
    do begin
      @(negedge clk);
      cnt++;
      if (cnt == 3) clk_sel = 2'($urandom);
      if (clkout_ok && c_clk < 0) c_clk = cnt;
      if (sys_rst_n && c_sys < 0) c_sys = cnt;
      if (stop_ok && c_stop < 0) c_stop = cnt;
    end while (c_sys < 0 && c_stop < 0 && cnt < 5000);
    chk("R6 clock-output flag delay", c_clk, exp_clkout());
    if (hold_stop) begin
      chk("R8 stop granted at lock deadline", c_stop, exp_lock(sel));
      chk("R8 system reset held", int'(sys_rst_n), 0);
    end else begin
      chk("R4 R3 lock wait for sampled code", c_sys, exp_lock(sel));
      chk("R4 ready with system reset", int'(ready), 1);
    end
  endtask

  task automatic resume();
    @(negedge clk);
    stop_req = 1'b0;
    @(negedge clk);
    chk("R7 permission removed first", int'(stop_ok), 0);
    chk("R7 system reset still low", int'(sys_rst_n), 0);
    @(negedge clk);
    chk("R7 system reset released", int'(sys_rst_n), 1);
    chk("R7 ready restored", int'(ready), 1);
  endtask

  task automatic stop_cycle();
    @(negedge clk);
    stop_req = 1'b1;
    @(negedge clk);
    chk("R7 system reset dropped", int'(sys_rst_n), 0);
    chk("R7 ready dropped", int'(ready), 0);
    chk("R7 no permission yet", int'(stop_ok), 0);
    @(negedge clk);
    chk("R7 permission granted", int'(stop_ok), 1);
    repeat (int'($urandom % 6)) @(negedge clk);
    chk("R9 init held during stop", int'(init_rst_n), 1);
    resume();
    chk("R9 init held after resume", int'(init_rst_n), 1);
  endtask

  task automatic power_drop();
    @(negedge clk);
    pwr_good = 1'b0;
    repeat (3) @(negedge clk);
    all_low("R10 outputs low after power loss");
  endtask

  task automatic abort_in_lock();
    int k;
    clk_sel = 2'($urandom);
    @(negedge clk);
    pwr_good = 1'b1;
    while (!init_rst_n) @(negedge clk);
    k = 1 + int'($urandom % (SHORT * D - 4));
    repeat (k) @(negedge clk);
    chk("R10 no release before deadline", int'(sys_rst_n), 0);
    power_drop();
  endtask

  initial begin
    n_checks = 0; n_errors = 0; finished = 1'b0; mon_bad = 0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; pwr_good = 1'b0; clk_sel = 2'd0; stop_req = 1'b0;
    repeat (3) @(negedge clk);
    all_low("R1 outputs during controller reset");
    rst_n = 1'b1;
    stop_req = 1'b1;
    repeat (20) @(negedge clk);
    all_low("R1 outputs without power, stop request ignored");
    stop_req = 1'b0;

    // Directed: every clock-select code, including reserved 3
    for (int s = 0; s < 4; s++) begin
      power_up(2'(s), 1'b0);
      stop_cycle();
      power_drop();
    end
    // Directed: stop request collides with lock deadline
    power_up(2'd0, 1'b1);
    resume();
    power_drop();

    // Random mix
    for (int i = 0; i < 16; i++) begin
      int mode;
      mode = int'($urandom % 4);
      case (mode)
        0: begin
             power_up(2'($urandom), 1'b1);
             resume();
           end
        1: abort_in_lock();
        default: begin
             power_up(2'($urandom), 1'b0);
             for (int j = 0; j < 1 + int'($urandom % 3); j++) stop_cycle();
           end
      endcase
      if (mode != 1) power_drop();
    end

    chk("R5 R7 ordering monitor", mon_bad, 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

endmodule